// File: doc/BRIEF.md
# Floating-Point Coprocessor Register Front End

This block is the host-side register file and operation dispatcher of a floating-point coprocessor. The host issues 32-bit writes and reads that carry a 4-bit register number. The block keeps a control/status word, a 32-bit staging word for the low half of 64-bit operands, and two 64-bit accumulators. Register numbers 4 to 15 are not storage. A write to one of them starts an arithmetic operation. The register number encodes both the operation and the accumulator it targets.

The arithmetic itself is done by a separate back end. An accepted operation write is passed to it as a request on a valid/ready handshake. The request carries the opcode, the accumulator index, the current accumulator value and the operand. The block then waits for the back end to return a 64-bit result and writes that result into the target accumulator. While an operation is in flight, the block holds off all host writes.

Access is gated by the status word. Only register 0 answers while the unit is disabled or not selected. Packing between the 32-bit and 64-bit formats is left to a separate adapter: this block only zero-extends short words and splices long ones.

Top module: `fpcop_regif`

## Requirements
- R1: After a synchronous active-high reset, the status word, the staging word and both accumulators are zero, rd_data is zero, op_valid is low and wr_ready is high.
- R2: Register 0 (status) can always be written and read back, whatever its own enable and select bits hold.
- R3: The unit is open only when status bit 1 is 1 and status bits 10:8 equal 3'b001. While it is closed, writes to registers 1 to 15 change nothing and start no operation, and reads of registers 1 to 15 return 0.
- R4: In short format (status bit 12 = 0), a write to register 2 or 3 stores the 32-bit word zero-extended into accumulator 0 or 1. A read of register 2 or 3 returns the accumulator's low 32 bits and leaves the staging word unchanged.
- R5: Register 1 is the staging word. In long format (status bit 12 = 1), a write to register 2 or 3 stores {written word, staging word} as the 64-bit accumulator value.
- R6: In long format, a read of register 2 or 3 returns the accumulator's high 32 bits and copies its low 32 bits into the staging word. If a staging write happens in the same cycle, the staging write wins.
- R7: A read of registers 4 to 15 returns 0.
- R8: An open write to register n in 4..15 raises op_valid with op_code = (n-4)/2 and op_acc = n[0]. The codes are int-convert=0, sqrt=1, add=2, sub=3, mul=4, div=5. op_b is the operand formed as in R4/R5, and op_a is the target accumulator's value. op_code, op_acc and op_b stay stable until op_ready is high.
- R9: From the cycle after an operation write is accepted until the cycle after res_valid returns in the waiting state, wr_ready is low. res_data is then written into the target accumulator. A res_valid with no operation waiting has no effect.
- R10: rd_data is registered. It shows the value for a read one cycle after rd_en and holds its value when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted this cycle when high |
| wr_addr | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 4 | Read register number |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| op_valid | output | 1 | Operation request to back end |
| op_ready | input | 1 | Back end takes the request |
| op_code | output | 3 | Operation code |
| op_acc | output | 1 | Target accumulator index |
| op_a | output | 64 | Current target accumulator value |
| op_b | output | 64 | Operand |
| res_valid | input | 1 | Result return from back end |
| res_data | input | 64 | Result value |

## Verification
The hardest situation to reach from the ports is an accumulator whose low half differs from the staging word. Only that case shows whether a long-format read really moves the low half into the staging word and whether a result writeback fills all 64 bits. The bench builds such states by loading in one format and reading in the other. It also rewrites the staging word between an accumulator load and its readback. In-flight operations are held in the request and waiting states for several cycles by delaying op_ready and res_valid, and a stray res_valid is sent while the block is idle.

// File: rtl/fpcop_pkg.sv
package fpcop_pkg;
  typedef enum logic [2:0] {
    OP_ITOF = 3'd0,
    OP_SQRT = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } fop_e;

  typedef enum logic [1:0] {
    K_STATUS,
    K_STAGE,
    K_ACC,
    K_OP
  } rkind_e;

  localparam int          EN_BIT  = 1;
  localparam int          SEL_LO  = 8;
  localparam int          SEL_HI  = 10;
  localparam int          FMT_BIT = 12;
  localparam logic [2:0]  MY_SEL  = 3'b001;
endpackage

// File: rtl/fpcop_decode.sv
module fpcop_decode
  import fpcop_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr,
  output rkind_e        kind,
  output logic [2:0]    code,
  output logic          acc
);
  localparam logic [AW-2:0] OP_BASE = (AW-1)'(2);

  always_comb begin
    logic [AW-2:0] pair;
    pair = addr[AW-1:1];
    acc  = addr[0];
    code = 3'(pair - OP_BASE);
    if (addr == '0)
      kind = K_STATUS;
    else if (addr == AW'(1))
      kind = K_STAGE;
    else if (pair == (AW-1)'(1))
      kind = K_ACC;
    else
      kind = K_OP;
  end
endmodule

// File: rtl/fpcop_dispatch.sv
module fpcop_dispatch #(
  parameter int OPW = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     start_code,
  input  logic           start_acc,
  input  logic [OPW-1:0] start_opnd,
  output logic           op_valid,
  input  logic           op_ready,
  output logic [2:0]     op_code,
  output logic           op_acc,
  output logic [OPW-1:0] op_b,
  input  logic           res_valid,
  output logic           wb_en,
  output logic           busy
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} dstate_e;
  dstate_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      op_code <= '0;
      op_acc  <= 1'b0;
      op_b    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_REQ;
          op_code <= start_code;
          op_acc  <= start_acc;
          op_b    <= start_opnd;
        end
        S_REQ:  if (op_ready)  state <= S_WAIT;
        S_WAIT: if (res_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign op_valid = (state == S_REQ);
  assign busy     = (state != S_IDLE);
  assign wb_en    = (state == S_WAIT) && res_valid;

  // R8: request fields hold until the back end takes them
  a_r8_req_stable: assert property (@(posedge clk) disable iff (rst)
    op_valid && !op_ready |=> op_valid && $stable(op_code) && $stable(op_acc) && $stable(op_b));

  // R9: no new operation may arrive while one is in flight
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/fpcop_regif.sv
module fpcop_regif
  import fpcop_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            op_valid,
  input  logic            op_ready,
  output logic [2:0]      op_code,
  output logic            op_acc,
  output logic [2*DW-1:0] op_a,
  output logic [2*DW-1:0] op_b,
  input  logic            res_valid,
  input  logic [2*DW-1:0] res_data
);
  localparam int OPW  = 2 * DW;
  localparam int NACC = 2;

  logic [DW-1:0]            status_q;
  logic [DW-1:0]            stage_q;
  logic [NACC-1:0][OPW-1:0] acc_q;

  rkind_e     wkind, rkind;
  logic [2:0] wcode, rcode_unused;
  logic       wacc, racc;

  fpcop_decode #(.AW(AW)) u_wdec (.addr(wr_addr), .kind(wkind), .code(wcode), .acc(wacc));
  fpcop_decode #(.AW(AW)) u_rdec (.addr(rd_addr), .kind(rkind), .code(rcode_unused), .acc(racc));

  logic gate_open, long_mode;
  assign gate_open = status_q[EN_BIT] && (status_q[SEL_HI:SEL_LO] == MY_SEL);
  assign long_mode = status_q[FMT_BIT];

  logic busy, wb_en, wr_ok, start;
  logic [OPW-1:0] operand;

  assign wr_ready = !busy;
  assign wr_ok    = wr_valid && wr_ready && (wkind == K_STATUS || gate_open);
  assign start    = wr_ok && (wkind == K_OP);
  assign operand  = long_mode ? {wr_data, stage_q} : {{DW{1'b0}}, wr_data};

  fpcop_dispatch #(.OPW(OPW)) u_disp (
    .clk(clk), .rst(rst),
    .start(start), .start_code(wcode), .start_acc(wacc), .start_opnd(operand),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_acc(op_acc),
    .op_b(op_b), .res_valid(res_valid), .wb_en(wb_en), .busy(busy)
  );

  assign op_a = acc_q[op_acc];

  // read data selection
  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rkind)
      K_STATUS: rd_next = status_q;
      K_STAGE:  if (gate_open) rd_next = stage_q;
      K_ACC:    if (gate_open)
                  rd_next = long_mode ? acc_q[racc][OPW-1:DW] : acc_q[racc][DW-1:0];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      stage_q  <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_ok && wkind == K_STATUS) status_q <= wr_data;
      if (rd_en && gate_open && long_mode && rkind == K_ACC)
        stage_q <= acc_q[racc][DW-1:0];
      if (wr_ok && wkind == K_STAGE) stage_q <= wr_data;
      if (rd_en) rd_data <= rd_next;
    end
  end

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[i] <= '0;
      else if (wb_en && op_acc == 1'(i))
        acc_q[i] <= res_data;
      else if (wr_ok && wkind == K_ACC && wacc == 1'(i))
        acc_q[i] <= operand;
    end
  end

  // R9: host writes are held off while a request is outstanding
  a_r9_hold_writes: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> !wr_ready);

  // R7: operation register numbers read back as zero
  a_r7_hidden_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en && rkind == K_OP |=> rd_data == '0);

  // R3: a new request only follows a cycle in which the enable bit was set
  a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(op_valid) |-> $past(status_q[EN_BIT]));

  // R10: read data holds while no read is requested
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/fpcop_regif_test.sv
module fpcop_regif_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic [2:0]  op_code;
  logic        op_acc;
  logic [63:0] op_a, op_b;
  logic        res_valid = 1'b0;
  logic [63:0] res_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] ST_ON   = 32'h0000_0102;
  localparam logic [31:0] ST_LONG = 32'h0000_1102;

  always #2 clk = ~clk;

  fpcop_regif uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_acc(op_acc),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic run_op(input logic [3:0] n, input logic [31:0] d, input logic [63:0] ea,
                        input logic [63:0] eb, input int rdly, input int sdly,
                        input logic [63:0] res, input string tag);
    wr(n, d);
    chk({tag, " R8 op_valid"}, op_valid, 1);
    chk({tag, " R8 op_code"}, op_code, 3'((n - 4) / 2));
    chk({tag, " R8 op_acc"}, op_acc, n[0]);
    chk({tag, " R8 op_a"}, op_a, ea);
    chk({tag, " R8 op_b"}, op_b, eb);
    chk({tag, " R9 wr_ready low"}, wr_ready, 0);
    for (int i = 0; i < rdly; i++) begin
      @(posedge clk); #1;
      chk({tag, " R8 held valid"}, op_valid, 1);
      chk({tag, " R8 held operand"}, op_b, eb);
    end
    op_ready = 1'b1;
    @(posedge clk); #1;
    op_ready = 1'b0;
    chk({tag, " R8 valid dropped"}, op_valid, 0);
    for (int i = 0; i < sdly; i++) begin
      @(posedge clk); #1;
      chk({tag, " R9 still busy"}, wr_ready, 0);
    end
    res_valid = 1'b1; res_data = res;
    @(posedge clk); #1;
    res_valid = 1'b0;
    chk({tag, " R9 ready again"}, wr_ready, 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);
    rd(4'd0, v); chk("R1 status", v, 0);
    wr(4'd0, ST_LONG);
    rd(4'd1, v); chk("R1 staging", v, 0);
    rd(4'd2, v); chk("R1 acc0 high", v, 0);
    rd(4'd3, v); chk("R1 acc1 high", v, 0);
    rd(4'd1, v); chk("R1 acc1 low via staging", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(4'd0, 32'hDEAD_0000);
    rd(4'd0, v); chk("R2 status while closed", v, 32'hDEAD_0000);
    wr(4'd2, 32'h1234_5678);
    wr(4'd1, 32'h0BAD_0BAD);
    rd(4'd2, v); chk("R3 closed read", v, 0);
    wr(4'd9, 32'h1);
    chk("R3 closed op no start", op_valid, 0);
    wr(4'd0, 32'h0000_0202);
    wr(4'd3, 32'h7777_7777);
    rd(4'd3, v); chk("R3 wrong select read", v, 0);
    wr(4'd0, ST_ON);
    rd(4'd2, v); chk("R3 acc0 untouched", v, 0);
    rd(4'd3, v); chk("R3 acc1 untouched", v, 0);
    rd(4'd1, v); chk("R3 staging untouched", v, 0);
  endtask

  task automatic t_short();
    logic [31:0] v;
    wr(4'd0, ST_ON);
    wr(4'd1, 32'h0000_0055);
    wr(4'd3, 32'hA5A5_0001);
    rd(4'd3, v); chk("R4 short acc1", v, 32'hA5A5_0001);
    rd(4'd1, v); chk("R4 staging unchanged", v, 32'h0000_0055);
    wr(4'd0, ST_LONG);
    rd(4'd3, v); chk("R4 zero extended high", v, 0);
    rd(4'd1, v); chk("R6 low to staging", v, 32'hA5A5_0001);
  endtask

  task automatic t_long();
    logic [31:0] v;
    wr(4'd0, ST_LONG);
    wr(4'd1, 32'h1111_2222);
    wr(4'd2, 32'h3333_4444);
    wr(4'd1, 32'h0);
    rd(4'd2, v); chk("R5 long acc0 high", v, 32'h3333_4444);
    rd(4'd1, v); chk("R6 staging from acc0", v, 32'h1111_2222);
    wr(4'd0, ST_ON);
    rd(4'd2, v); chk("R4 short view of long", v, 32'h1111_2222);
  endtask

  task automatic t_hidden();
    logic [31:0] v;
    wr(4'd0, ST_ON);
    rd(4'd2, v); chk("R10 nonzero before", v, 32'h1111_2222);
    rd(4'd4, v); chk("R7 reg4", v, 0);
    rd(4'd2, v);
    rd(4'd9, v); chk("R7 reg9", v, 0);
    rd(4'd2, v);
    rd(4'd15, v); chk("R7 reg15", v, 0);
    repeat (2) @(posedge clk);
    #1 chk("R10 rd_data holds", rd_data, 0);
  endtask

  task automatic t_op_short();
    logic [31:0] v;
    wr(4'd0, ST_ON);
    run_op(4'd9, 32'h40, 64'h0000_0000_A5A5_0001, 64'h40, 2, 2,
           64'hCAFE_0000_BEEF_0001, "add short");
    wr(4'd0, ST_LONG);
    rd(4'd3, v); chk("R9 result high", v, 32'hCAFE_0000);
    rd(4'd1, v); chk("R9 result low", v, 32'hBEEF_0001);
  endtask

  task automatic t_op_long();
    logic [31:0] v;
    wr(4'd0, ST_LONG);
    wr(4'd1, 32'h7);
    run_op(4'd14, 32'h8000_0000, 64'h3333_4444_1111_2222, 64'h8000_0000_0000_0007,
           0, 0, 64'h1, "div long");
    rd(4'd2, v); chk("R9 div result high", v, 0);
    rd(4'd1, v); chk("R9 div result low", v, 32'h1);
  endtask

  task automatic t_decode_all();
    logic [63:0] cur [2];
    logic [31:0] v;
    wr(4'd0, ST_ON);
    wr(4'd2, 32'h10);
    wr(4'd3, 32'h20);
    cur[0] = 64'h10; cur[1] = 64'h20;
    for (int n = 4; n < 16; n++) begin
      run_op(4'(n), 32'(n * 3), cur[n % 2], 64'(n * 3), 0, 1, 64'(n + 100), "decode");
      cur[n % 2] = 64'(n + 100);
    end
    rd(4'd2, v); chk("R8 last acc0 result", v, 32'd114);
    rd(4'd3, v); chk("R8 last acc1 result", v, 32'd115);
  endtask

  task automatic t_stray_res();
    logic [31:0] v;
    wr(4'd0, ST_ON);
    res_valid = 1'b1; res_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(posedge clk); #1;
    res_valid = 1'b0;
    rd(4'd2, v); chk("R9 stray result acc0", v, 32'd114);
    rd(4'd3, v); chk("R9 stray result acc1", v, 32'd115);
    chk("R9 stray ready", wr_ready, 1);
  endtask

  task automatic t_stage_race();
    logic [31:0] v;
    wr(4'd0, ST_LONG);
    wr(4'd1, 32'h0000_AAAA);
    wr(4'd2, 32'h0000_BBBB);
    rd_en = 1'b1; rd_addr = 4'd2;
    wr(4'd1, 32'h0000_CCCC);
    rd_en = 1'b0;
    rd(4'd1, v); chk("R6 staging write wins", v, 32'h0000_CCCC);
  endtask

  initial begin
    t_reset();
    t_gate();
    t_short();
    t_long();
    t_hidden();
    t_op_short();
    t_op_long();
    t_decode_all();
    t_stray_res();
    t_stage_race();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule